// File: doc/BRIEF.md
# Bit-Banged Serial Memory Responder

This block answers a two-wire serial memory protocol from a 256-entry by 8-bit array that is loaded with a computed pattern at reset. It has no bus clock of its own. The host writes both line levels, clock and data, through a one-cycle update strobe. The block compares each new pair of levels with the pair it stored on the previous update. From that comparison it recognises start and stop conditions, rising clock edges and data bits.

After a start it shifts in a command byte and then a word address, most significant bit first, and returns an acknowledge after each of them. The last command bit received is the read flag. When that flag is set, each address bit clock also drives the current read-data byte onto the line. At the end of the address phase, the byte at the new address is loaded as the read data for the next access. The single output is the data level the block holds after its overrides. A host model reads it back as the line state.

Top module: `bitbang_rom_resp`

## Requirements
- R1: After reset the stored clock and data levels are both 1, the reported data level is 1, and no transfer is active.
- R2: While no transfer is active and no acknowledge is pending, rising clock edges are ignored and no acknowledge ever appears. Only a start condition begins a transfer.
- R3: A falling data level while the clock is high on both the stored and the new sample is a start condition. It restarts the bit count and clears the command, including in the middle of a transfer.
- R4: A rising data level while the clock is high on both samples is a stop condition. It leaves the bit count and any pending acknowledge unchanged.
- R5: A bit is taken only on a rising clock edge whose data level equals the stored data level. A rising edge that also changes the data level takes no bit.
- R6: The first 8 bits after a start form the command, MSB first. On the next rising clock edge the block drives data low (acknowledge) instead of taking a bit.
- R7: The next 8 bits form the word address, MSB first. When command bit 0 is 0, the reported level on each of these edges is the host's data level.
- R8: When command bit 0 is 1, on each address bit edge the reported level is the MSB of the read-data register, and that register then shifts left by one.
- R9: On the 8th address bit the read-data register is loaded from the array at the complete new address, an acknowledge is flagged, and the transfer returns to inactive. The driven MSB on that same edge comes from the old register contents.
- R10: Array entry i holds (i*SEED_MUL + SEED_ADD) mod 256, by default (i*37 + 90) mod 256. No bus activity changes the array.
- R11: Between updates, and while the strobe is low, the reported level holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | One-cycle strobe: the host has written new line levels |
| scl_i | input | 1 | Host serial clock level |
| sda_i | input | 1 | Host serial data level |
| sda_o | output | 1 | Data level stored by the responder after acknowledge/read overrides |

## Verification
The last address bit of a read transfer does two things on one update. It drives the final bit of the old read byte onto the line, and it loads the register with the byte at the address just completed. The bench runs two read transfers back to back. It checks that the 8th driven bit of the first read still belongs to the previous byte. It also checks that the second read returns, MSB first, the byte whose address ended the first. The same update also raises the acknowledge and returns the transfer to inactive, so the bench checks that the very next rising edge drives low.

// File: rtl/brr_pkg.sv
package brr_pkg;

  // Preload pattern of one array entry.
  function automatic logic [31:0] seed_word(input int unsigned idx,
                                            input int unsigned mul,
                                            input int unsigned add);
    return 32'((idx * mul + add) & 32'hFF);
  endfunction

  // Shift a new bit into the LSB end of an 8-bit shifter.
  function automatic logic [7:0] push_lsb(input logic [7:0] v, input logic b);
    return {v[6:0], b};
  endfunction

endpackage

// File: rtl/brr_line_decode.sv
module brr_line_decode (
  input  logic upd_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic scl_q,
  input  logic sda_q,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic steady
);
  logic cond;

  assign cond     = upd_i && scl_q && scl_i && (sda_q != sda_i);
  assign start_ev = cond && !sda_i;
  assign stop_ev  = cond && sda_i;
  assign rise_ev  = upd_i && !scl_q && scl_i;
  assign steady   = (sda_q == sda_i);
endmodule

// File: rtl/brr_rom.sv
module brr_rom #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int SEED_MUL = 37,
  parameter int SEED_ADD = 90
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  import brr_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Loaded at reset, never written afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= DW'(seed_word(i, SEED_MUL, SEED_ADD));
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/brr_seq.sv
module brr_seq #(
  parameter int CW = 8,
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          rise_ev,
  input  logic          steady,
  input  logic [DW-1:0] rom_rdata,
  output logic [AW-1:0] rom_raddr,
  output logic          scl_q,
  output logic          sda_q
);
  localparam int TW = $clog2(CW + AW + 2);
  localparam logic [TW-1:0] T_CMD_END  = TW'(CW);
  localparam logic [TW-1:0] T_ADDR_END = TW'(CW + AW);

  logic [TW-1:0] tick;
  logic [CW-1:0] cmd;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          ack;

  logic idle, in_cmd, in_addr, take_bit, is_read;

  assign idle      = (tick == '0) && !ack;
  assign in_cmd    = (tick != '0) && (tick <= T_CMD_END);
  assign in_addr   = (tick > T_CMD_END) && (tick <= T_ADDR_END);
  assign take_bit  = rise_ev && !ack && steady && !idle;
  assign is_read   = cmd[0];
  assign rom_raddr = {addr[AW-2:0], sda_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick  <= '0;
      cmd   <= '0;
      addr  <= '0;
      data  <= '0;
      ack   <= 1'b0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (upd_i) begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_ev) begin
        tick <= TW'(1);
        cmd  <= '0;
      end else if (stop_ev || idle) begin
        // level stored only
      end else if (rise_ev) begin
        if (ack) begin
          sda_q <= 1'b0;
          ack   <= 1'b0;
        end else if (steady) begin
          if (in_cmd) begin
            cmd  <= {cmd[CW-2:0], sda_i};
            tick <= tick + TW'(1);
            if (tick == T_CMD_END) ack <= 1'b1;
          end else if (in_addr) begin
            if (is_read) sda_q <= data[DW-1];
            addr <= rom_raddr;
            if (tick == T_ADDR_END) begin
              data <= rom_rdata;
              ack  <= 1'b1;
              tick <= '0;
            end else begin
              data <= {data[DW-2:0], 1'b0};
              tick <= tick + TW'(1);
            end
          end else begin
            sda_q <= 1'b0;
          end
        end
      end
    end
  end

  a_r1_reset_levels: assert property (@(posedge clk)
    $rose(rst_n) |-> (scl_q && sda_q && idle));
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && idle && !start_ev) |=> (tick == '0));
  a_r3_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (tick == TW'(1) && cmd == '0));
  a_r4_stop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> ($stable(tick) && $stable(ack)));
  a_r5_skew_no_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && !steady && !ack) |=> ($stable(tick) && $stable(cmd) && $stable(addr)));
  a_r6_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && ack) |=> (!sda_q && !ack));
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= T_ADDR_END);
  a_r9_addr_end: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && tick == T_ADDR_END) |=> (ack && tick == '0));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> ($stable(sda_q) && $stable(scl_q)));
endmodule

// File: rtl/bitbang_rom_resp.sv
module bitbang_rom_resp #(
  parameter int CW       = 8,
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int SEED_MUL = 37,
  parameter int SEED_ADD = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o
);
  logic          start_ev, stop_ev, rise_ev, steady;
  logic          scl_q, sda_q;
  logic [AW-1:0] rom_raddr;
  logic [DW-1:0] rom_rdata;

  brr_line_decode u_dec (
    .upd_i(upd_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q),
    .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev), .steady(steady)
  );

  brr_rom #(.AW(AW), .DW(DW), .SEED_MUL(SEED_MUL), .SEED_ADD(SEED_ADD)) u_rom (
    .clk(clk), .rst_n(rst_n), .raddr(rom_raddr), .rdata(rom_rdata)
  );

  brr_seq #(.CW(CW), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .scl_i(scl_i), .sda_i(sda_i),
    .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev), .steady(steady),
    .rom_rdata(rom_rdata), .rom_raddr(rom_raddr), .scl_q(scl_q), .sda_q(sda_q)
  );

  assign sda_o = sda_q;
endmodule

// File: tb/bitbang_rom_resp_bench.sv
module bitbang_rom_resp_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_i = 1'b0;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic sda_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] rd_model = 8'h00;  // expected read-data register contents

  always #5 clk = ~clk;

  bitbang_rom_resp u_bitbang_rom_resp (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i),
    .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_o)
  );

  function automatic logic [7:0] exp_byte(input int a);
    int v;
    v = a * 37 + 90;
    return 8'(v % 256);
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic line(input logic s, input logic d);
    @(negedge clk);
    scl_i = s; sda_i = d; upd_i = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
  endtask

  task automatic bit_chk(input logic b, input logic exp, input string tag);
    line(1'b0, b);
    line(1'b1, b);
    chk(sda_o, exp, tag);
  endtask

  task automatic start_cond();
    line(1'b0, 1'b1);
    line(1'b1, 1'b1);
    line(1'b1, 1'b0);
  endtask

  task automatic byte_chk(input logic [7:0] host, input logic [7:0] exp, input string tag);
    for (int k = 7; k >= 0; k--) bit_chk(host[k], exp[k], tag);
  endtask

  task automatic ack_chk(input string tag);
    bit_chk(1'b1, 1'b0, tag);
  endtask

  // Address phase plus its acknowledge; updates the read-data model.
  task automatic addr_phase(input logic rd, input logic [7:0] a, input string tag);
    byte_chk(a, rd ? rd_model : a, tag);
    rd_model = exp_byte(a);
    ack_chk("R9 address acknowledge");
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sda_o, 1'b1, "R1 reset level");
    repeat (3) @(negedge clk);
    chk(sda_o, 1'b1, "R11 hold without strobe");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 10; i++) bit_chk(1'b1, 1'b1, "R2 idle no ack");
  endtask

  task automatic t_write(input logic [7:0] a);
    start_cond();
    byte_chk(8'hA0, 8'hA0, "R6 command bits");
    ack_chk("R6 command acknowledge");
    addr_phase(1'b0, a, "R7 write address follows host");
  endtask

  task automatic t_read(input logic [7:0] a, input string tag);
    start_cond();
    byte_chk(8'hA1, 8'hA1, "R6 command bits");
    ack_chk("R6 command acknowledge");
    addr_phase(1'b1, a, tag);
  endtask

  task automatic t_ignored_data();
    // data bits after a write transfer: inactive, must not alter the array
    byte_chk(8'h00, 8'h00, "R10 trailing data ignored");
    bit_chk(1'b1, 1'b1, "R2 no ack after ignored data");
  endtask

  task automatic t_skew();
    start_cond();
    for (int i = 0; i < 3; i++) bit_chk(1'b1, 1'b1, "R5 command bit");
    line(1'b0, 1'b0);
    line(1'b1, 1'b1);       // data changes with the rising edge
    chk(sda_o, 1'b1, "R5 skewed edge level");
    for (int i = 0; i < 5; i++) bit_chk(1'b1, 1'b1, "R5 no early ack");
    ack_chk("R5 ack after eight real bits");
    addr_phase(1'b1, 8'h33, "R8 read after skew");
  endtask

  task automatic t_stop();
    start_cond();
    bit_chk(1'b1, 1'b1, "R4 bit");
    bit_chk(1'b0, 1'b0, "R4 bit");
    bit_chk(1'b1, 1'b1, "R4 bit");
    bit_chk(1'b0, 1'b0, "R4 bit");
    line(1'b1, 1'b1);       // stop condition
    chk(sda_o, 1'b1, "R4 stop level");
    for (int i = 0; i < 4; i++) bit_chk(1'b0, 1'b0, "R4 bit after stop");
    ack_chk("R4 count kept across stop");
    addr_phase(1'b0, 8'h7E, "R7 write address");
  endtask

  task automatic t_restart();
    start_cond();
    for (int i = 0; i < 3; i++) bit_chk(1'b1, 1'b1, "R3 partial command");
    start_cond();
    byte_chk(8'hA1, 8'hA1, "R3 command after restart");
    ack_chk("R3 ack after restart");
    addr_phase(1'b1, 8'h01, "R8 read after restart");
  endtask

  initial begin
    t_reset();
    t_idle();
    t_write(8'hFF);
    t_read(8'h00, "R8 R10 read byte at FF");
    t_read(8'h5C, "R9 coincident load byte at 00");
    t_write(8'h10);
    t_ignored_data();
    t_read(8'h80, "R10 array unchanged at 10");
    t_skew();
    t_stop();
    t_restart();
    t_read(8'h02, "R9 byte at 01");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule